// File: doc/BRIEF.md
# Host Access Bridge with Direct and Staged Memory Access

This block sits between an asynchronous, non-multiplexed host bus and the internal connection and data memories, which can only be touched in the access slots of the switching state machine. The host chip select is brought into the internal clock domain through a two-stage synchroniser. Address, direction and write data are sampled only after that point. The host must hold them stable while chip select is low.

A direct access to either memory holds the host cycle: the active-low acknowledge stays high until the access is done. For a write, that is when the memory slot is granted. For a read, that is when the returned word has been captured. The connection memory can be read and written. The data memory is read-only from the host, and a write to it is acknowledged but never reaches memory.

For hosts that cannot take wait states, there is a staged path. The host writes a staging address and a staging data register, then writes a command register, which launches one transfer. It then polls a status word while the transfer waits for a slot. Register accesses need no memory slot and are acknowledged at once.

Inside the block, direct and staged requests meet a single slot arbiter. A request is a valid signal with its fields. The ready for that request is `slot_tick & ~dp_busy`: one host slot per channel time, and the switching datapath has priority. While a request is not granted it stays valid and its fields do not change. A memory read returns `mem_rdata` exactly one cycle after the granted cycle.

Top module: `hab_host_bridge`

## Requirements
- R1: After reset, `host_dta_n` is high, `mem_en` is low and the status word reads 0.
- R2: `host_cs_n` passes through two synchroniser flops. A register access lowers `host_dta_n` on the third rising edge after `host_cs_n` falls. `host_dta_n` rises on the third rising edge after `host_cs_n` rises.
- R3: A direct write to connection memory (`host_addr[13:12]`=0, `host_rw`=0) issues exactly one memory write with `mem_sel`=0 and the host's address and data. The acknowledge follows the grant.
- R4: A direct read (`host_addr[13:12]`=0 for connection memory, 1 for data memory, `host_rw`=1) returns the `mem_rdata` of the cycle after the grant on `host_rdata` while `host_dta_n` is low. `mem_sel` is 1 for data memory.
- R5: No host action ever produces `mem_en` with `mem_sel`=1 and `mem_we`=1. A direct data-memory write is acknowledged and dropped. A staged write command to data memory sets status bit 3 (refused) and starts nothing.
- R6: `mem_en` is only asserted in a cycle with `slot_tick`=1 and `dp_busy`=0. An ungranted request keeps its address and data.
- R7: When a direct and a staged request both wait for a slot, the direct one is granted first.
- R8: Register space is `host_addr[13:12]`=2, with the index in `host_addr[2:0]`: 0 staging address, 1 staging data, 2 command (bit0 = write, bit1 = data memory), 3 status, 4 result. A command write launches one transfer from a snapshot of the staging registers. Status bit 2 (pending) is set until it completes.
- R9: Completion sets status bit 0 (done). An accepted command write clears done, busy and refused.
- R10: A command write while a transfer is pending is ignored and sets status bit 1 (busy). The pending transfer keeps its original address.
- R11: A staged read loads the returned word into the result register in the same edge that sets done.
- R12: Register accesses and accesses to `host_addr[13:12]`=3 need no memory slot. Space 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 14 | Host address: [13:12] space, low bits offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid while acknowledge is low |
| host_dta_n | output | 1 | Data transfer acknowledge, active low |
| slot_tick | input | 1 | Host access slot of this channel time |
| dp_busy | input | 1 | Switching datapath claims the memory this cycle |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | 1 = write |
| mem_sel | output | 1 | 0 = connection memory, 1 = data memory |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, one cycle after the access |

## Verification
The bench holds `dp_busy` high so that requests back up. It then checks three things: that no memory cycle leaks out, that a second command issued during the wait is rejected with the busy bit rather than overwriting the pending address, and that on release the direct request beats the staged one. A design without these protections would show the wrong result word, the wrong access order, or a stray access while the datapath is busy.

The bench also sends writes to the read-only data memory on both paths. A broken design would show a data-memory write on the memory port or a missing refused bit. It measures the exact acknowledge latency on both edges of chip select, which exposes a missing or extra synchroniser stage. It checks that done clears on a new command and that the result word matches the returned data.

// File: rtl/hab_pkg.sv
package hab_pkg;

  typedef enum logic [1:0] {
    SP_CM   = 2'd0,
    SP_DM   = 2'd1,
    SP_REG  = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_REQ  = 2'd1,
    DS_WAIT = 2'd2,
    DS_ACK  = 2'd3
  } dir_state_e;

  localparam int unsigned RIDX_W      = 3;
  localparam logic [2:0]  RI_ADDR     = 3'd0;
  localparam logic [2:0]  RI_WDATA    = 3'd1;
  localparam logic [2:0]  RI_CMD      = 3'd2;
  localparam logic [2:0]  RI_STATUS   = 3'd3;
  localparam logic [2:0]  RI_RESULT   = 3'd4;

  localparam int unsigned ST_DONE     = 0;
  localparam int unsigned ST_BUSY     = 1;
  localparam int unsigned ST_PENDING  = 2;
  localparam int unsigned ST_REFUSED  = 3;

  localparam int unsigned CMD_WRITE   = 0;
  localparam int unsigned CMD_DM      = 1;

endpackage

// File: rtl/hab_sync.sv
module hab_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hab_slot_arb.sv
module hab_slot_arb #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_tick,
  input  logic          dp_busy,
  input  logic          dir_valid,
  input  logic          dir_we,
  input  logic          dir_sel,
  input  logic [AW-1:0] dir_addr,
  input  logic [DW-1:0] dir_wdata,
  input  logic          ind_valid,
  input  logic          ind_we,
  input  logic          ind_sel,
  input  logic [AW-1:0] ind_addr,
  input  logic [DW-1:0] ind_wdata,
  output logic          dir_gnt,
  output logic          ind_gnt,
  output logic          dir_rret,
  output logic          ind_rret,
  output logic          mem_en,
  output logic          mem_we,
  output logic          mem_sel,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic slot_free;

  assign slot_free = slot_tick & ~dp_busy;
  assign dir_gnt   = slot_free & dir_valid;
  assign ind_gnt   = slot_free & ind_valid & ~dir_valid;

  always_comb begin
    if (dir_valid) begin
      mem_we    = dir_we;
      mem_sel   = dir_sel;
      mem_addr  = dir_addr;
      mem_wdata = dir_wdata;
    end else begin
      mem_we    = ind_we;
      mem_sel   = ind_sel;
      mem_addr  = ind_addr;
      mem_wdata = ind_wdata;
    end
  end

  assign mem_en = dir_gnt | ind_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_rret <= 1'b0;
      ind_rret <= 1'b0;
    end else begin
      dir_rret <= dir_gnt & ~dir_we;
      ind_rret <= ind_gnt & ~ind_we;
    end
  end

  a_r6_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (slot_tick && !dp_busy));
  a_r5_no_dm_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_sel) |-> !mem_we);
  a_r7_direct_first: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && ind_valid && mem_en) |-> (dir_gnt && !ind_gnt));
endmodule

// File: rtl/hab_direct.sv
module hab_direct
  import hab_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 16,
  parameter int unsigned HAW = AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              host_rw,
  input  logic [HAW-1:0]    host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_dta_n,
  output logic              dir_valid,
  output logic              dir_we,
  output logic              dir_sel,
  output logic [AW-1:0]     dir_addr,
  output logic [DW-1:0]     dir_wdata,
  input  logic              dir_gnt,
  input  logic              dir_rret,
  input  logic [DW-1:0]     mem_rdata,
  output logic              reg_wr,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [DW-1:0]     reg_wdata,
  input  logic [DW-1:0]     reg_rdata
);
  dir_state_e    st;
  space_e        space;
  logic          cap_rw;
  logic          cap_sel;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wdata;

  assign space     = space_e'(host_addr[HAW-1 -: 2]);
  assign reg_idx   = host_addr[RIDX_W-1:0];
  assign reg_wdata = host_wdata;
  assign reg_wr    = (st == DS_IDLE) && cs_act && (space == SP_REG) && !host_rw;

  assign dir_valid  = (st == DS_REQ);
  assign dir_we     = ~cap_rw;
  assign dir_sel    = cap_sel;
  assign dir_addr   = cap_addr;
  assign dir_wdata  = cap_wdata;
  assign host_dta_n = (st != DS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= DS_IDLE;
      cap_rw     <= 1'b1;
      cap_sel    <= 1'b0;
      cap_addr   <= '0;
      cap_wdata  <= '0;
      host_rdata <= '0;
    end else begin
      case (st)
        DS_IDLE: if (cs_act) begin
          cap_rw    <= host_rw;
          cap_sel   <= (space == SP_DM);
          cap_addr  <= host_addr[AW-1:0];
          cap_wdata <= host_wdata;
          case (space)
            SP_REG: begin
              if (host_rw) host_rdata <= reg_rdata;
              st <= DS_ACK;
            end
            SP_NONE: begin
              host_rdata <= '0;
              st <= DS_ACK;
            end
            SP_DM: st <= host_rw ? DS_REQ : DS_ACK;
            default: st <= DS_REQ;
          endcase
        end
        DS_REQ:  if (dir_gnt) st <= cap_rw ? DS_WAIT : DS_ACK;
        DS_WAIT: if (dir_rret) begin
          host_rdata <= mem_rdata;
          st <= DS_ACK;
        end
        default: if (!cs_act) st <= DS_IDLE;
      endcase
    end
  end

  a_r2_ack_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_dta_n) |-> cs_act);
  a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_dta_n && !cs_act) |=> host_dta_n);
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !dir_gnt) |=> (dir_valid && $stable(dir_addr) && $stable(dir_wdata)));
endmodule

// File: rtl/hab_indirect.sv
module hab_indirect
  import hab_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              ind_valid,
  output logic              ind_we,
  output logic              ind_sel,
  output logic [AW-1:0]     ind_addr,
  output logic [DW-1:0]     ind_wdata,
  input  logic              ind_gnt,
  input  logic              ind_rret,
  input  logic [DW-1:0]     mem_rdata
);
  logic [AW-1:0] stg_addr;
  logic [DW-1:0] stg_wdata;
  logic [1:0]    cmd_q;
  logic          pending, inflight, done, busy, refused;
  logic [DW-1:0] result;
  logic          cmd_wr, cmd_refuse, cmd_accept;
  logic [3:0]    status;

  assign cmd_wr     = reg_wr && (reg_idx == RI_CMD);
  assign cmd_refuse = cmd_wr && !pending && reg_wdata[CMD_WRITE] && reg_wdata[CMD_DM];
  assign cmd_accept = cmd_wr && !pending && !cmd_refuse;
  assign ind_valid  = pending && !inflight;

  assign status[ST_DONE]    = done;
  assign status[ST_BUSY]    = busy;
  assign status[ST_PENDING] = pending;
  assign status[ST_REFUSED] = refused;

  always_comb begin
    case (reg_idx)
      RI_ADDR:   reg_rdata = DW'(stg_addr);
      RI_WDATA:  reg_rdata = stg_wdata;
      RI_CMD:    reg_rdata = DW'(cmd_q);
      RI_STATUS: reg_rdata = DW'(status);
      RI_RESULT: reg_rdata = result;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_addr  <= '0;
      stg_wdata <= '0;
      cmd_q     <= '0;
      ind_we    <= 1'b0;
      ind_sel   <= 1'b0;
      ind_addr  <= '0;
      ind_wdata <= '0;
      pending   <= 1'b0;
      inflight  <= 1'b0;
      done      <= 1'b0;
      busy      <= 1'b0;
      refused   <= 1'b0;
      result    <= '0;
    end else begin
      if (reg_wr && reg_idx == RI_ADDR)  stg_addr  <= reg_wdata[AW-1:0];
      if (reg_wr && reg_idx == RI_WDATA) stg_wdata <= reg_wdata;
      if (cmd_wr && pending) busy <= 1'b1;
      if (cmd_refuse) begin
        cmd_q   <= reg_wdata[1:0];
        refused <= 1'b1;
        done    <= 1'b0;
        busy    <= 1'b0;
      end
      if (cmd_accept) begin
        cmd_q     <= reg_wdata[1:0];
        ind_we    <= reg_wdata[CMD_WRITE];
        ind_sel   <= reg_wdata[CMD_DM];
        ind_addr  <= stg_addr;
        ind_wdata <= stg_wdata;
        pending   <= 1'b1;
        done      <= 1'b0;
        busy      <= 1'b0;
        refused   <= 1'b0;
      end
      if (ind_gnt) begin
        if (ind_we) begin
          pending <= 1'b0;
          done    <= 1'b1;
        end else begin
          inflight <= 1'b1;
        end
      end
      if (ind_rret) begin
        result   <= mem_rdata;
        done     <= 1'b1;
        pending  <= 1'b0;
        inflight <= 1'b0;
      end
    end
  end

  a_r10_busy_keeps_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && pending) |=> (busy && pending && $stable(ind_addr)));
  a_r9_accept_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (!done && !busy && pending));
  a_r11_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ind_rret |=> (done && result == $past(mem_rdata)));
  a_r5_refuse_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refuse |=> (refused && !pending));
endmodule

// File: rtl/hab_host_bridge.sv
module hab_host_bridge #(
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HAW        = AW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_cs_n,
  input  logic           host_rw,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_dta_n,
  input  logic           slot_tick,
  input  logic           dp_busy,
  output logic           mem_en,
  output logic           mem_we,
  output logic           mem_sel,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  import hab_pkg::*;

  logic              cs_act;
  logic              dir_valid, dir_we, dir_sel, dir_gnt, dir_rret;
  logic [AW-1:0]     dir_addr;
  logic [DW-1:0]     dir_wdata;
  logic              ind_valid, ind_we, ind_sel, ind_gnt, ind_rret;
  logic [AW-1:0]     ind_addr;
  logic [DW-1:0]     ind_wdata;
  logic              reg_wr;
  logic [RIDX_W-1:0] reg_idx;
  logic [DW-1:0]     reg_wdata, reg_rdata;

  hab_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(~host_cs_n), .sync_out(cs_act)
  );

  hab_direct #(.AW(AW), .DW(DW), .HAW(HAW)) u_direct (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .host_rw(host_rw), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_dta_n(host_dta_n),
    .dir_valid(dir_valid), .dir_we(dir_we), .dir_sel(dir_sel),
    .dir_addr(dir_addr), .dir_wdata(dir_wdata),
    .dir_gnt(dir_gnt), .dir_rret(dir_rret), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  hab_indirect #(.AW(AW), .DW(DW)) u_indirect (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ind_valid(ind_valid), .ind_we(ind_we), .ind_sel(ind_sel),
    .ind_addr(ind_addr), .ind_wdata(ind_wdata),
    .ind_gnt(ind_gnt), .ind_rret(ind_rret), .mem_rdata(mem_rdata)
  );

  hab_slot_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .dp_busy(dp_busy),
    .dir_valid(dir_valid), .dir_we(dir_we), .dir_sel(dir_sel),
    .dir_addr(dir_addr), .dir_wdata(dir_wdata),
    .ind_valid(ind_valid), .ind_we(ind_we), .ind_sel(ind_sel),
    .ind_addr(ind_addr), .ind_wdata(ind_wdata),
    .dir_gnt(dir_gnt), .ind_gnt(ind_gnt), .dir_rret(dir_rret), .ind_rret(ind_rret),
    .mem_en(mem_en), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && host_dta_n) |=> host_dta_n);
endmodule

// File: tb/test_hab_host_bridge.sv
module test_hab_host_bridge;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_cs_n = 1'b1;
  logic          host_rw = 1'b1;
  logic [13:0]   host_addr = '0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic          host_dta_n;
  logic          slot_tick = 1'b0;
  logic          dp_busy = 1'b0;
  logic          mem_en, mem_we, mem_sel;
  logic [11:0]   mem_addr;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  hab_host_bridge #(.AW(AW), .DW(DW)) i_hab_host_bridge (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rw(host_rw),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_dta_n(host_dta_n), .slot_tick(slot_tick), .dp_busy(dp_busy),
    .mem_en(mem_en), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] dm_val(input logic [11:0] a);
    return ({4'h0, a} * 16'h0101) ^ 16'h3C5A;
  endfunction

  logic [15:0] cm [4096];
  int dm_writes = 0;
  int slot_viol = 0;
  logic [11:0] log_addr[$];
  logic        log_sel[$];
  logic        log_we[$];
  logic [15:0] log_wdata[$];

  always @(posedge clk) begin
    if (mem_en) begin
      log_addr.push_back(mem_addr);
      log_sel.push_back(mem_sel);
      log_we.push_back(mem_we);
      log_wdata.push_back(mem_wdata);
      if (!slot_tick || dp_busy) slot_viol++;
      if (mem_we && mem_sel) dm_writes++;
      if (mem_we && !mem_sel) cm[mem_addr] <= mem_wdata;
      if (!mem_we) mem_rdata <= mem_sel ? dm_val(mem_addr) : cm[mem_addr];
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % 4;
      slot_tick = (cnt == 0);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard for memory reads
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          mon_rd = 0;
  bit          prev_dta = 1;

  always @(negedge clk) begin
    if (mon_rd && prev_dta && !host_dta_n) begin
      if (exp_q.size() == 0) check(0, "scoreboard empty", host_rdata, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
    prev_dta = host_dta_n;
  end

  task automatic host_cycle(input bit rd, input logic [13:0] a, input logic [15:0] wd,
                            output logic [15:0] rv, output int lon, output int loff);
    @(negedge clk);
    host_rw = rd; host_addr = a; host_wdata = wd; host_cs_n = 1'b0;
    lon = 0;
    do begin @(negedge clk); lon++; end while (host_dta_n && lon < 2000);
    rv = host_rdata;
    host_cs_n = 1'b1;
    loff = 0;
    do begin @(negedge clk); loff++; end while (!host_dta_n && loff < 2000);
  endtask

  task automatic mem_read_chk(input logic [13:0] a, input logic [15:0] e, input string t);
    logic [15:0] rv; int l0, l1;
    exp_q.push_back(e); tag_q.push_back(t);
    mon_rd = 1;
    host_cycle(1'b1, a, '0, rv, l0, l1);
    mon_rd = 0;
  endtask

  task automatic host_wr(input logic [13:0] a, input logic [15:0] d);
    logic [15:0] rv; int l0, l1;
    host_cycle(1'b0, a, d, rv, l0, l1);
  endtask

  function automatic logic [13:0] ra(input logic [2:0] idx);
    return {2'b10, 9'd0, idx};
  endfunction

  task automatic reg_rd(input logic [2:0] idx, output logic [15:0] v);
    int l0, l1;
    host_cycle(1'b1, ra(idx), '0, v, l0, l1);
  endtask

  task automatic wait_done(output logic [15:0] st);
    int n = 0;
    do begin reg_rd(3'd3, st); n++; end while (!st[0] && n < 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int lon, loff, en_seen;
    for (int i = 0; i < 4096; i++) cm[i] = 16'(i) ^ 16'hA5A5;

    // R1: reset state
    en_seen = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_en) en_seen++;
    end
    check(host_dta_n === 1'b1, "R1 dta_n after reset", {15'd0, host_dta_n}, 16'h1);
    check(en_seen == 0, "R1 no mem_en after reset", 16'(en_seen), 16'h0);
    reg_rd(3'd3, v);
    check(v === 16'h0, "R1 status after reset", v, 16'h0);

    // R2 / R12: register access latency
    host_cycle(1'b0, ra(3'd0), 16'h0ABC, v, lon, loff);
    check(lon == 3, "R2 ack assert latency", 16'(lon), 16'd3);
    check(loff == 3, "R2 ack release latency", 16'(loff), 16'd3);
    host_cycle(1'b1, ra(3'd0), '0, v, lon, loff);
    check(v === 16'h0ABC && lon == 3, "R12 staging addr readback without slot", v, 16'h0ABC);
    host_wr(14'h3005, 16'hFFFF);
    host_cycle(1'b1, 14'h3005, '0, v, lon, loff);
    check(v === 16'h0 && lon == 3, "R12 space 3 reads zero", v, 16'h0);

    // R3: direct connection memory write
    log_addr.delete(); log_sel.delete(); log_we.delete(); log_wdata.delete();
    host_wr(14'h0123, 16'hBEEF);
    check(log_addr.size() == 1, "R3 one memory access", 16'(log_addr.size()), 16'd1);
    if (log_addr.size() == 1)
      check(log_addr[0] == 12'h123 && log_we[0] && !log_sel[0] && log_wdata[0] == 16'hBEEF,
            "R3 write fields", log_wdata[0], 16'hBEEF);

    // R4: direct reads
    mem_read_chk(14'h0123, 16'hBEEF, "R4 CM readback");
    mem_read_chk(14'h1005, dm_val(12'h005), "R4 DM read 0x005");
    mem_read_chk(14'h1FFF, dm_val(12'hFFF), "R4 DM read 0xFFF");
    mem_read_chk(14'h0FFF, 16'h0FFF ^ 16'hA5A5, "R4 CM read top address");

    // R5: data memory writes dropped
    host_wr(14'h1005, 16'h1111);
    check(dm_writes == 0, "R5 direct DM write dropped", 16'(dm_writes), 16'h0);
    mem_read_chk(14'h1005, dm_val(12'h005), "R5 DM unchanged");
    host_wr(ra(3'd0), 16'h0010);
    host_wr(ra(3'd2), 16'h0003);
    reg_rd(3'd3, v);
    check(v === 16'h0008, "R5 staged DM write refused", v, 16'h0008);
    check(dm_writes == 0, "R5 no DM write on port", 16'(dm_writes), 16'h0);

    // R8 / R9: staged write to connection memory
    host_wr(ra(3'd0), 16'h00AA);
    host_wr(ra(3'd1), 16'h1234);
    host_wr(ra(3'd2), 16'h0001);
    wait_done(v);
    check(v === 16'h0001, "R9 done after staged write", v, 16'h0001);
    mem_read_chk(14'h00AA, 16'h1234, "R8 staged write landed");

    // R11: staged reads
    host_wr(ra(3'd0), 16'h0777);
    host_wr(ra(3'd2), 16'h0002);
    wait_done(v);
    reg_rd(3'd4, v);
    check(v === dm_val(12'h777), "R11 staged DM read result", v, dm_val(12'h777));
    host_wr(ra(3'd0), 16'h0123);
    host_wr(ra(3'd2), 16'h0000);
    wait_done(v);
    reg_rd(3'd4, v);
    check(v === 16'hBEEF, "R11 staged CM read result", v, 16'hBEEF);

    // R9 / R10 / R6: command during pending
    dp_busy = 1'b1;
    slot_viol = 0;
    host_wr(ra(3'd0), 16'h00AA);
    host_wr(ra(3'd2), 16'h0000);
    reg_rd(3'd3, v);
    check(v === 16'h0004, "R9 accepted command clears done, pending set", v, 16'h0004);
    host_wr(ra(3'd0), 16'h0001);
    host_wr(ra(3'd2), 16'h0000);
    reg_rd(3'd3, v);
    check(v === 16'h0006, "R10 busy set while pending", v, 16'h0006);
    @(negedge clk);
    dp_busy = 1'b0;
    wait_done(v);
    check(v === 16'h0003, "R10 done with busy kept", v, 16'h0003);
    reg_rd(3'd4, v);
    check(v === 16'h1234, "R10 original address kept", v, 16'h1234);
    check(slot_viol == 0, "R6 no access off slot or while datapath busy", 16'(slot_viol), 16'h0);

    // R7: direct wins over pending staged request
    dp_busy = 1'b1;
    host_wr(ra(3'd0), 16'h00AA);
    host_wr(ra(3'd2), 16'h0000);
    log_addr.delete(); log_sel.delete(); log_we.delete(); log_wdata.delete();
    fork
      mem_read_chk(14'h0123, 16'hBEEF, "R7 direct read under contention");
      begin
        repeat (12) @(negedge clk);
        dp_busy = 1'b0;
      end
    join
    check(log_addr.size() >= 1 && log_addr[0] == 12'h123, "R7 direct granted first",
          log_addr.size() >= 1 ? 16'(log_addr[0]) : 16'hFFFF, 16'h0123);
    wait_done(v);
    reg_rd(3'd4, v);
    check(v === 16'h1234, "R7 staged completes after", v, 16'h1234);
    check(slot_viol == 0, "R6 slot rule held", 16'(slot_viol), 16'h0);
    check(dm_writes == 0, "R5 no DM write overall", 16'(dm_writes), 16'h0);
    check(exp_q.size() == 0, "R4 scoreboard drained", 16'(exp_q.size()), 16'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule